// File: doc/BRIEF.md
# I2C Bit-Level Timing Engine

This block turns single commands into the wire-level signalling of an I2C controller. The transfer core above it asks for one of four operations: a START (which becomes a repeated START when the clock is already held low), a STOP, a byte write, or a byte read that ends with a chosen acknowledge value. The engine then produces open-drain pull-down enables for SCL and SDA. It samples both lines back through two-flop synchronizers and pulses `done` when the operation is over. After a write it reports the acknowledge bit the slave returned. After a read it reports the received byte and the acknowledge bit seen on the bus.

Bit timing comes from one 32-bit divisor word. The upper half sets the SCL high phase and the lower half sets the SCL low phase. Each half is counted in units of eight input clocks. A slave may stretch the clock, because the high-phase count only starts once SCL reads back high. Data changes in the middle of the low phase and is sampled in the middle of the high phase. Between byte commands SCL is held low, so the core can chain bytes without releasing the bus.

Top module: `i2c_bit_timer`

## Requirements
- R1: After reset both pull-downs are released (`scl_oe`=0, `sda_oe`=0), and `busy` and `done` are 0.
- R2: During a byte, SCL is held low for exactly 8*LO input clocks, where LO is `divisor[15:0]`. The high phase is counted for 8*HI input clocks, where HI is `divisor[31:16]`, starting once SCL is seen high through the two-flop synchronizer. With no stretching the line is released for 8*HI+2 clocks.
- R3: A divisor field of zero is timed as if it held one (8 clocks per phase).
- R4: START (`cmd_op`=2'b00) pulls SDA low while SCL is released. It keeps SDA low with SCL high for exactly 8*HI clocks, then pulls SCL low and finishes with `scl_oe`=1 and `sda_oe`=1. If SCL is held low when the START is issued, SDA is first released mid-low and SCL released, which forms a repeated START.
- R5: STOP (`cmd_op`=2'b01) pulls SDA low mid-low and releases SCL. After the high phase it releases SDA while SCL is high, and it finishes with both pull-downs released.
- R6: Write (`cmd_op`=2'b10) shifts `cmd_wdata` out MSB first over eight clocks. During a byte SDA never changes while SCL is high.
- R7: On the ninth clock of a write, SDA is released and the bus value sampled mid-high is returned on `ack_out` (0 means acknowledged).
- R8: Read (`cmd_op`=2'b11) releases SDA for eight clocks, samples each bit mid-high, and presents the byte MSB first on `rd_data`.
- R9: On the ninth clock of a read, SDA carries `cmd_ack` (0 pulls low) and the sampled bus value is returned on `ack_out`.
- R10: While a slave holds SCL low after release, the high-phase count waits. The bus high time then still lasts 8*HI clocks plus synchronizer delay.
- R11: `cmd_valid` is ignored while `busy` is 1.
- R12: `done` is a one-cycle pulse, given in the cycle in which `busy` returns to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| divisor | input | 32 | [31:16] high-phase count, [15:0] low-phase count |
| cmd_valid | input | 1 | Command request, taken when idle |
| cmd_op | input | 2 | 00 START, 01 STOP, 10 write byte, 11 read byte |
| cmd_wdata | input | 8 | Byte to send on a write |
| cmd_ack | input | 1 | Acknowledge value to drive after a read |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Last byte shifted in |
| ack_out | output | 1 | Acknowledge bit sampled on the ninth clock |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The bench keeps the default 16-bit fields with a scale of eight. This keeps phase lengths short (LO=2, HI=3, so 16 and 24 clocks), which makes exact cycle counts of every low run, high run and START hold practical to check. A zero divisor exercises the minimum 8-clock phases. A bench slave that stretches the clock by 20 clocks shows the high count waiting for the line. The same slave answers writes with chosen acknowledges and feeds bytes on reads, and the bench decodes START and STOP from the wire levels alone.

// File: rtl/i2c_bit_timer.sv
module i2c_bit_timer #(
  parameter int CNT_W      = 16,
  parameter int SCALE_LOG2 = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2*CNT_W-1:0] divisor,
  input  logic               cmd_valid,
  input  logic [1:0]         cmd_op,
  input  logic [7:0]         cmd_wdata,
  input  logic               cmd_ack,
  output logic               busy,
  output logic               done,
  output logic [7:0]         rd_data,
  output logic               ack_out,
  input  logic               scl_in,
  input  logic               sda_in,
  output logic               scl_oe,
  output logic               sda_oe
);
  localparam int TW = CNT_W + SCALE_LOG2;
  localparam logic [1:0] OP_START = 2'b00;
  localparam logic [1:0] OP_WR    = 2'b10;
  localparam logic [1:0] OP_RD    = 2'b11;

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH, S_HOLD} st_t;
  st_t st;

  logic [1:0]    op;
  logic [7:0]    wdat, sh;
  logic          ackv, ack_r, done_r, scl_drv, sda_drv;
  logic [TW-1:0] cnt;
  logic [3:0]    bitn;
  logic          scl_m, scl_s, sda_m, sda_s;

  wire [CNT_W-1:0] lo_c = (divisor[CNT_W-1:0] == '0) ? CNT_W'(1) : divisor[CNT_W-1:0];
  wire [CNT_W-1:0] hi_c = (divisor[2*CNT_W-1:CNT_W] == '0) ? CNT_W'(1) : divisor[2*CNT_W-1:CNT_W];
  wire [TW-1:0] lo_len = {lo_c, {SCALE_LOG2{1'b0}}};
  wire [TW-1:0] hi_len = {hi_c, {SCALE_LOG2{1'b0}}};

  wire last_lo = (cnt == lo_len - TW'(1));
  wire last_hi = (cnt == hi_len - TW'(1));
  wire mid_lo  = (cnt == (lo_len >> 1));
  wire mid_hi  = (cnt == (hi_len >> 1));
  wire is_byte = op[1];
  wire ninth   = (bitn == 4'd8);

  wire bit_val = ninth ? ((op == OP_RD) ? ackv : 1'b1)
                       : ((op == OP_WR) ? wdat[3'd7 - bitn[2:0]] : 1'b1);
  wire low_val = is_byte ? bit_val : (op == OP_START);

  assign busy    = (st != S_IDLE);
  assign done    = done_r;
  assign rd_data = sh;
  assign ack_out = ack_r;
  assign scl_oe  = scl_drv;
  assign sda_oe  = sda_drv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      op      <= OP_START;
      wdat    <= '0;
      ackv    <= 1'b0;
      sh      <= '0;
      ack_r   <= 1'b0;
      done_r  <= 1'b0;
      scl_drv <= 1'b0;
      sda_drv <= 1'b0;
      cnt     <= '0;
      bitn    <= '0;
      scl_m   <= 1'b1;
      scl_s   <= 1'b1;
      sda_m   <= 1'b1;
      sda_s   <= 1'b1;
    end else begin
      scl_m  <= scl_in;
      scl_s  <= scl_m;
      sda_m  <= sda_in;
      sda_s  <= sda_m;
      done_r <= 1'b0;
      case (st)
        S_IDLE: if (cmd_valid) begin
          op   <= cmd_op;
          wdat <= cmd_wdata;
          ackv <= cmd_ack;
          bitn <= '0;
          cnt  <= '0;
          if (cmd_op == OP_START && !scl_drv) begin
            st <= S_HIGH;
          end else begin
            st      <= S_LOW;
            scl_drv <= 1'b1;
          end
        end
        S_LOW: begin
          cnt <= cnt + TW'(1);
          if (mid_lo) sda_drv <= ~low_val;
          if (last_lo) begin
            cnt     <= '0;
            scl_drv <= 1'b0;
            st      <= S_HIGH;
          end
        end
        S_HIGH: if (scl_s) begin
          cnt <= cnt + TW'(1);
          if (mid_hi && is_byte) begin
            if (ninth) ack_r <= sda_s;
            else       sh    <= {sh[6:0], sda_s};
          end
          if (last_hi) begin
            cnt <= '0;
            if (is_byte) begin
              scl_drv <= 1'b1;
              if (ninth) begin
                st     <= S_IDLE;
                done_r <= 1'b1;
              end else begin
                bitn <= bitn + 4'd1;
                st   <= S_LOW;
              end
            end else begin
              sda_drv <= (op == OP_START);
              st      <= S_HOLD;
            end
          end
        end
        S_HOLD: begin
          cnt <= cnt + TW'(1);
          if (last_hi) begin
            cnt <= '0;
            if (op == OP_START) scl_drv <= 1'b1;
            st     <= S_IDLE;
            done_r <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_bit_timer_chk.sv
module i2c_bit_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [1:0] cmd_op,
  input logic       busy,
  input logic       done,
  input logic       scl_oe,
  input logic       sda_oe
);
  logic [1:0] cur_op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_op <= 2'b00;
    else if (cmd_valid && !busy) cur_op <= cmd_op;
  end

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R12
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R6
  byte_sda_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cur_op[1] && !scl_oe && $past(!scl_oe)) |-> $stable(sda_oe));

  // R4
  start_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cur_op == 2'b00) |-> (scl_oe && sda_oe));

  // R5
  stop_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cur_op == 2'b01) |-> (!scl_oe && !sda_oe));
endmodule

bind i2c_bit_timer i2c_bit_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .busy(busy), .done(done), .scl_oe(scl_oe), .sda_oe(sda_oe)
);

// File: tb/i2c_bit_timer_tb.sv
`timescale 1ns/1ps
module i2c_bit_timer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] divisor = {16'd3, 16'd2};
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [7:0] cmd_wdata = 8'h00;
  logic cmd_ack = 1'b0;
  logic busy, done, ack_out, scl_oe, sda_oe;
  logic [7:0] rd_data;

  int checks = 0, fails = 0, cyc = 0;
  int hrun = 0, lrun = 0, last_high = 0, last_low = 0, crun = 0, last_crun = 0;
  int starts = 0, stops = 0, viol = 0, dones = 0, bitidx = 9, scnt = 0;
  int stretch_len = 20;
  bit do_stretch = 0, slave_en = 0, slave_rd = 0, slave_ack = 0, timeout = 0;
  logic [7:0] slave_tx = 8'h00;
  logic [8:0] cap = '0;
  logic prev_scl = 1'b1, prev_sda = 1'b1;

  wire slave_low = slave_en && ((slave_rd && bitidx < 8) ? !slave_tx[7-bitidx]
                                 : (!slave_rd && bitidx == 8) ? !slave_ack : 1'b0);
  wire scl_bus = !scl_oe && (scnt == 0);
  wire sda_bus = !sda_oe && !slave_low;

  always #2.5 clk = ~clk;

  i2c_bit_timer u_dut (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_wdata(cmd_wdata), .cmd_ack(cmd_ack), .busy(busy),
    .done(done), .rd_data(rd_data), .ack_out(ack_out), .scl_in(scl_bus),
    .sda_in(sda_bus), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic sb, db;
    cyc++;
    sb = scl_bus;
    db = sda_bus;
    if (done) dones++;
    if (sb) begin
      if (!prev_scl) begin last_low = lrun; hrun = 1; cap = {cap[7:0], db}; end
      else hrun++;
    end else begin
      if (prev_scl) begin last_high = hrun; lrun = 1; bitidx++; end
      else lrun++;
    end
    if (sb && prev_scl && prev_sda && !db) starts++;
    if (sb && prev_scl && !prev_sda && db) stops++;
    if (slave_en && sb && prev_scl && db != prev_sda) viol++;
    if (sb && !db) crun++;
    else begin
      if (crun != 0) last_crun = crun;
      crun = 0;
    end
    prev_scl = sb;
    prev_sda = db;
    if (scl_oe && do_stretch) scnt = stretch_len;
    else if (scnt > 0) scnt--;
    if (cyc == 150000) begin
      timeout = 1;
      fails++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic issue(input logic [1:0] op, input logic [7:0] d, input logic a);
    @(negedge clk); #1;
    cmd_valid = 1'b1; cmd_op = op; cmd_wdata = d; cmd_ack = a;
    bitidx = 0; cap = '0;
    @(negedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done();
    while (!done && !timeout) begin @(negedge clk); #1; end
    @(negedge clk); #1;
    check(!done, "R12 done single cycle", done, 0);
  endtask

  task automatic run(input logic [1:0] op, input logic [7:0] d, input logic a);
    issue(op, d, a);
    wait_done();
  endtask

  localparam logic [9:0] VEC [5] = '{
    {1'b0, 8'hA5, 1'b0}, {1'b0, 8'h3C, 1'b1}, {1'b1, 8'h96, 1'b0},
    {1'b1, 8'h01, 1'b1}, {1'b0, 8'hFF, 1'b0}
  };

  initial begin
    int d0, s0;
    #12;
    check(scl_oe == 0 && sda_oe == 0, "R1 pulls released", {scl_oe, sda_oe}, 0);
    check(busy == 0 && done == 0, "R1 idle", {busy, done}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    s0 = starts;
    run(2'b00, 8'h00, 1'b0);
    check(scl_oe && sda_oe, "R4 start end state", {scl_oe, sda_oe}, 3);
    check(starts == s0 + 1, "R4 start seen", starts - s0, 1);
    check(last_crun == 24, "R4 start hold", last_crun, 24);

    foreach (VEC[i]) begin
      slave_rd = VEC[i][9]; slave_tx = VEC[i][8:1]; slave_ack = VEC[i][0];
      slave_en = 1; viol = 0;
      run(VEC[i][9] ? 2'b11 : 2'b10, VEC[i][8:1], VEC[i][0]);
      slave_en = 0;
      if (!VEC[i][9]) begin
        check(cap[8:1] == VEC[i][8:1], "R6 write bits", cap[8:1], VEC[i][8:1]);
        check(ack_out == VEC[i][0], "R7 write ack", ack_out, VEC[i][0]);
      end else begin
        check(rd_data == VEC[i][8:1], "R8 read byte", rd_data, VEC[i][8:1]);
        check(cap[0] == VEC[i][0], "R9 driven ack on bus", cap[0], VEC[i][0]);
        check(ack_out == VEC[i][0], "R9 returned ack", ack_out, VEC[i][0]);
      end
      check(viol == 0, "R6 sda stable while scl high", viol, 0);
    end

    run(2'b10, 8'h5A, 1'b0);
    check(last_low == 16, "R2 low phase", last_low, 16);
    check(last_high == 26, "R2 high phase", last_high, 26);

    divisor = 32'h0;
    run(2'b10, 8'hC3, 1'b0);
    check(last_low == 8, "R3 zero low count", last_low, 8);
    check(last_high == 10, "R3 zero high count", last_high, 10);
    divisor = {16'd3, 16'd2};

    do_stretch = 1;
    run(2'b10, 8'h81, 1'b0);
    do_stretch = 0;
    check(last_low == 36, "R10 stretched low", last_low, 36);
    check(last_high == 25, "R10 high after stretch", last_high, 25);

    d0 = dones;
    issue(2'b10, 8'h77, 1'b0);
    repeat (40) @(negedge clk);
    #1; cmd_valid = 1'b1; cmd_op = 2'b01;
    @(negedge clk); #1; cmd_valid = 1'b0;
    wait_done();
    repeat (60) @(negedge clk);
    check(dones == d0 + 1, "R11 busy command ignored", dones - d0, 1);
    check(busy == 0 && scl_oe == 1, "R11 no stop taken", {busy, scl_oe}, 1);

    s0 = starts;
    run(2'b00, 8'h00, 1'b0);
    check(starts == s0 + 1, "R4 repeated start seen", starts - s0, 1);
    check(scl_oe && sda_oe, "R4 repeated start end", {scl_oe, sda_oe}, 3);
    check(last_crun == 24, "R4 repeated start hold", last_crun, 24);

    s0 = stops;
    run(2'b01, 8'h00, 1'b0);
    repeat (4) @(negedge clk);
    check(stops == s0 + 1, "R5 stop seen", stops - s0, 1);
    check(!scl_oe && !sda_oe, "R5 stop end state", {scl_oe, sda_oe}, 0);
    check(busy == 0, "R12 busy low after done", busy, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule